// File: doc/BRIEF.md
# Lockstep Dual-ROB Verified Retirement

This block retires instructions for a pair of pipelines that execute the same thread in lockstep. Each pipeline owns a small circular reorder buffer. Both buffers receive the same instruction stream through their own allocation ports. Execution results come back through separate completion ports, and each ROB marks the addressed slot as finished.

Retirement is split over two pipelined cycles. In the first cycle the oldest entries of both buffers are removed together and compared field by field. The destination register, the store flag, the result value and the store address must all agree. An entry that agrees moves to a second register stage. In the following cycle it drives either a register-file write or a memory write. No unverified value ever reaches architectural state or memory.

When the two entries disagree, nothing is written for that instruction. Both buffers are emptied, and a one-cycle flush pulse asks the front end to re-execute. A verified entry already sitting in the second stage still commits. One pair can enter the compare stage every cycle.

Top module: `dvc_verified_commit`

## Requirements
- R1: After reset both ROBs are empty, not full, and report slot 0 as the next allocation slot. No register write, memory write or flush is asserted.
- R2: Allocation slots are handed out consecutively and wrap modulo DEPTH (16). Full is raised once DEPTH entries are held. An allocation request while full is ignored, so the next slot and the full flag are unchanged.
- R3: An entry pair leaves the buffers only when both head entries are marked finished. When only one head is finished, nothing retires.
- R4: Entries retire strictly in allocation order, whatever order their completions arrive in.
- R5: A verified entry commits in the cycle after it leaves the buffers. If its store flag is 1, it drives mem_we with mem_addr equal to the store address and mem_wdata equal to the value, and rf_we stays low. If its store flag is 0, it drives rf_we with rf_waddr equal to the destination and rf_wdata equal to the value, and mem_we stays low.
- R6: If the two heads differ in destination, store flag, value or address, that instruction writes neither the register file nor memory. Flush is high for exactly one cycle, the cycle after the compare.
- R7: On a mismatch both ROBs are emptied, so the next allocation slot returns to 0 and finished younger entries never retire. The verified entry already in the second stage still commits, one cycle before the flush.
- R8: With finished heads available, one instruction retires every cycle.
- R9: A completion addressed to a slot that is not occupied, including the slot being allocated in the same cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_alloc_valid | input | 1 | Allocate an entry in the main ROB |
| m_alloc_dest | input | 5 | Destination register of the new main entry |
| m_alloc_store | input | 1 | New main entry is a store |
| m_alloc_idx | output | 4 | Slot the next main allocation takes |
| m_full | output | 1 | Main ROB is full |
| m_done_valid | input | 1 | Main completion strobe |
| m_done_idx | input | 4 | Main slot being completed |
| m_done_value | input | 32 | Result value for the main slot |
| m_done_addr | input | 32 | Store address for the main slot |
| s_alloc_valid | input | 1 | Allocate an entry in the shadow ROB |
| s_alloc_dest | input | 5 | Destination register of the new shadow entry |
| s_alloc_store | input | 1 | New shadow entry is a store |
| s_alloc_idx | output | 4 | Slot the next shadow allocation takes |
| s_full | output | 1 | Shadow ROB is full |
| s_done_valid | input | 1 | Shadow completion strobe |
| s_done_idx | input | 4 | Shadow slot being completed |
| s_done_value | input | 32 | Result value for the shadow slot |
| s_done_addr | input | 32 | Store address for the shadow slot |
| rf_we | output | 1 | Verified register write |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_we | output | 1 | Verified memory write |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| flush | output | 1 | One-cycle flush and re-execute request |

## Verification
The assertions assume that the two allocation ports are driven in lockstep with the same instruction sequence. They also assume that completions name slot indices produced by allocation, one completion per ROB per cycle. Under those inputs the occupancy count cannot pass DEPTH, and a dequeue only happens on a ready head. The stimulus always allocates to both buffers in the same cycle. It injects divergence only through the payload fields, one field per mismatch case. The only out-of-range completions it sends are deliberate ones aimed at a slot that is not occupied.

// File: rtl/dvc_pkg.sv
package dvc_pkg;
  parameter int REG_W  = 5;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 32;

  typedef struct packed {
    logic [REG_W-1:0]  dest;
    logic              store;
    logic [DATA_W-1:0] value;
    logic [ADDR_W-1:0] addr;
  } rob_entry_t;

  // Field-by-field agreement of two retiring entries.
  function automatic logic entries_agree(input rob_entry_t a, input rob_entry_t b);
    return (a.dest == b.dest) && (a.store == b.store) &&
           (a.value == b.value) && (a.addr == b.addr);
  endfunction
endpackage

// File: rtl/dvc_rob.sv
module dvc_rob
  import dvc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              alloc_store,
  output logic [PTR_W-1:0]  alloc_idx,
  output logic              full,
  output logic              empty,
  input  logic              done_valid,
  input  logic [PTR_W-1:0]  done_idx,
  input  logic [DATA_W-1:0] done_value,
  input  logic [ADDR_W-1:0] done_addr,
  output rob_entry_t        head,
  output logic              head_ready,
  input  logic              deq,
  input  logic              clear
);

  logic [REG_W-1:0]  dest_q  [DEPTH];
  logic              store_q [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [DEPTH-1:0]  done_q;
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Distance of a slot from the head, counted in allocation order.
  function automatic logic [CNT_W-1:0] slot_offset(input logic [PTR_W-1:0] idx,
                                                   input logic [PTR_W-1:0] hd);
    if (idx >= hd) return CNT_W'(idx) - CNT_W'(hd);
    return CNT_W'(idx) + CNT_W'(DEPTH) - CNT_W'(hd);
  endfunction

  logic alloc_ok, done_ok, deq_ok, done_occupied;

  assign full          = (count_q == CNT_W'(DEPTH));
  assign empty         = (count_q == '0);
  assign alloc_idx     = tail_q;
  assign done_occupied = slot_offset(done_idx, head_q) < count_q;
  assign alloc_ok      = alloc_valid && !full && !clear;
  assign done_ok       = done_valid && done_occupied && !clear;
  assign deq_ok        = deq && !clear;

  assign head       = '{dest: dest_q[head_q], store: store_q[head_q],
                        value: value_q[head_q], addr: addr_q[head_q]};
  assign head_ready = !empty && done_q[head_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (clear) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_ok) tail_q <= ptr_next(tail_q);
      if (deq_ok)   head_q <= ptr_next(head_q);
      count_q <= count_q + CNT_W'(alloc_ok) - CNT_W'(deq_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else if (clear) begin
      done_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_ok && tail_q == PTR_W'(e))     done_q[e] <= 1'b0;
        else if (done_ok && done_idx == PTR_W'(e)) done_q[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (alloc_ok && tail_q == PTR_W'(e)) begin
        dest_q[e]  <= alloc_dest;
        store_q[e] <= alloc_store;
      end
      if (done_ok && done_idx == PTR_W'(e)) begin
        value_q[e] <= done_value;
        addr_q[e]  <= done_addr;
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  assert_deq_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> head_ready);

endmodule

// File: rtl/dvc_commit_pair.sv
module dvc_commit_pair
  import dvc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rob_entry_t        m_head,
  input  rob_entry_t        s_head,
  input  logic              m_ready,
  input  logic              s_ready,
  output logic              fire,
  output logic              mismatch,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              flush
);

  logic       agree;
  logic       s2_valid_q;
  rob_entry_t s2_entry_q;
  logic       flush_q;

  // Stage one: both heads are taken together and compared.
  assign fire     = m_ready && s_ready;
  assign agree    = entries_agree(m_head, s_head);
  assign mismatch = fire && !agree;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
      s2_entry_q <= '0;
      flush_q    <= 1'b0;
    end else begin
      s2_valid_q <= fire && agree;
      flush_q    <= mismatch;
      if (fire) s2_entry_q <= m_head;
    end
  end

  // Stage two: the verified entry drives exactly one write.
  assign rf_we     = s2_valid_q && !s2_entry_q.store;
  assign rf_waddr  = s2_entry_q.dest;
  assign rf_wdata  = s2_entry_q.value;
  assign mem_we    = s2_valid_q && s2_entry_q.store;
  assign mem_addr  = s2_entry_q.addr;
  assign mem_wdata = s2_entry_q.value;
  assign flush     = flush_q;

  assert_commit_verified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || mem_we) |-> $past(fire && agree));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, flush}));

  assert_flush_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flush);

  assert_flush_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

endmodule

// File: rtl/dvc_verified_commit.sv
module dvc_verified_commit
  import dvc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_alloc_valid,
  input  logic [REG_W-1:0]  m_alloc_dest,
  input  logic              m_alloc_store,
  output logic [PTR_W-1:0]  m_alloc_idx,
  output logic              m_full,
  input  logic              m_done_valid,
  input  logic [PTR_W-1:0]  m_done_idx,
  input  logic [DATA_W-1:0] m_done_value,
  input  logic [ADDR_W-1:0] m_done_addr,
  input  logic              s_alloc_valid,
  input  logic [REG_W-1:0]  s_alloc_dest,
  input  logic              s_alloc_store,
  output logic [PTR_W-1:0]  s_alloc_idx,
  output logic              s_full,
  input  logic              s_done_valid,
  input  logic [PTR_W-1:0]  s_done_idx,
  input  logic [DATA_W-1:0] s_done_value,
  input  logic [ADDR_W-1:0] s_done_addr,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              flush
);

  rob_entry_t m_head, s_head;
  logic       m_ready, s_ready, m_empty, s_empty;
  logic       pair_fire, pair_mismatch;

  dvc_rob #(.DEPTH(DEPTH)) main_rob_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(m_alloc_valid), .alloc_dest(m_alloc_dest), .alloc_store(m_alloc_store),
    .alloc_idx(m_alloc_idx), .full(m_full), .empty(m_empty),
    .done_valid(m_done_valid), .done_idx(m_done_idx),
    .done_value(m_done_value), .done_addr(m_done_addr),
    .head(m_head), .head_ready(m_ready),
    .deq(pair_fire), .clear(pair_mismatch)
  );

  dvc_rob #(.DEPTH(DEPTH)) shadow_rob_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(s_alloc_valid), .alloc_dest(s_alloc_dest), .alloc_store(s_alloc_store),
    .alloc_idx(s_alloc_idx), .full(s_full), .empty(s_empty),
    .done_valid(s_done_valid), .done_idx(s_done_idx),
    .done_value(s_done_value), .done_addr(s_done_addr),
    .head(s_head), .head_ready(s_ready),
    .deq(pair_fire), .clear(pair_mismatch)
  );

  dvc_commit_pair commit_i (
    .clk(clk), .rst_n(rst_n),
    .m_head(m_head), .s_head(s_head), .m_ready(m_ready), .s_ready(s_ready),
    .fire(pair_fire), .mismatch(pair_mismatch),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .flush(flush)
  );

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (m_empty && s_empty));

  assert_lockstep_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_full == s_full);

endmodule

// File: tb/dvc_verified_commit_tb_top.sv
`timescale 1ns/1ps
module dvc_verified_commit_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_alloc_valid, m_alloc_store, m_full, m_done_valid;
  logic [4:0]  m_alloc_dest;
  logic [3:0]  m_alloc_idx, m_done_idx;
  logic [31:0] m_done_value, m_done_addr;
  logic        s_alloc_valid, s_alloc_store, s_full, s_done_valid;
  logic [4:0]  s_alloc_dest;
  logic [3:0]  s_alloc_idx, s_done_idx;
  logic [31:0] s_done_value, s_done_addr;
  logic        rf_we, mem_we, flush;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata, mem_addr, mem_wdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dvc_verified_commit dut_i (.*);

  function automatic logic [31:0] val_of(int i);
    return 32'hC0DE0000 + i * 32'h00010203;
  endfunction
  function automatic logic [31:0] addr_of(int i);
    return 32'h00004000 + i * 8;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    m_alloc_valid = 0; m_alloc_dest = 0; m_alloc_store = 0;
    s_alloc_valid = 0; s_alloc_dest = 0; s_alloc_store = 0;
    m_done_valid = 0; m_done_idx = 0; m_done_value = 0; m_done_addr = 0;
    s_done_valid = 0; s_done_idx = 0; s_done_value = 0; s_done_addr = 0;
  endtask

  task automatic alloc_pair(logic [4:0] dm, logic [4:0] ds, logic sm, logic ss);
    m_alloc_valid = 1; m_alloc_dest = dm; m_alloc_store = sm;
    s_alloc_valid = 1; s_alloc_dest = ds; s_alloc_store = ss;
  endtask

  task automatic done_m(int idx, logic [31:0] v, logic [31:0] a);
    m_done_valid = 1; m_done_idx = 4'(idx); m_done_value = v; m_done_addr = a;
  endtask
  task automatic done_s(int idx, logic [31:0] v, logic [31:0] a);
    s_done_valid = 1; s_done_idx = 4'(idx); s_done_value = v; s_done_addr = a;
  endtask

  task automatic expect_none(string req);
    chk(!rf_we && !mem_we, req, {rf_we, mem_we}, 0);
    chk(!flush, req, flush, 0);
  endtask

  task automatic expect_commit(string req, logic [4:0] d, logic st, logic [31:0] v, logic [31:0] a);
    chk(!flush, req, flush, 0);
    if (st) begin
      chk(mem_we && !rf_we, req, {rf_we, mem_we}, 2'b01);
      chk(mem_addr == a && mem_wdata == v, req, {mem_addr, mem_wdata}, {a, v});
    end else begin
      chk(rf_we && !mem_we, req, {rf_we, mem_we}, 2'b10);
      chk(rf_waddr == d && rf_wdata == v, req, {rf_waddr, rf_wdata}, {d, v});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk(!m_full && !s_full, "R1 full", {m_full, s_full}, 0);
    chk(m_alloc_idx == 0 && s_alloc_idx == 0, "R1 idx", {m_alloc_idx, s_alloc_idx}, 0);
    expect_none("R1");

    // R2: fill all slots, indices consecutive
    for (int i = 0; i < DEPTH; i++) begin
      if (i > 0) @(negedge clk);
      idle();
      chk(m_alloc_idx == 4'(i) && s_alloc_idx == 4'(i), "R2 slot", {m_alloc_idx, s_alloc_idx}, {4'(i), 4'(i)});
      chk(!m_full, "R2 not full", m_full, 0);
      alloc_pair(5'(i + 1), 5'(i + 1), (i % 3) == 0, (i % 3) == 0);
    end
    @(negedge clk);
    idle();
    chk(m_full && s_full, "R2 full", {m_full, s_full}, 2'b11);
    alloc_pair(5'd31, 5'd31, 1'b0, 1'b0);
    @(negedge clk);
    idle();
    chk(m_full && s_full, "R2 full kept", {m_full, s_full}, 2'b11);
    chk(m_alloc_idx == 0 && s_alloc_idx == 0, "R2 ignored alloc", {m_alloc_idx, s_alloc_idx}, 0);

    // R4: complete in reverse order; shadow head held back (R3)
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (k != DEPTH - 1) @(negedge clk);
      idle();
      done_m(k, val_of(k), addr_of(k));
      if (k != 0) done_s(k, val_of(k), addr_of(k));
    end
    repeat (3) begin
      @(negedge clk);
      idle();
      expect_none("R3 one head done");
    end
    @(negedge clk);
    idle();
    done_s(0, val_of(0), addr_of(0));
    @(negedge clk);
    idle();
    expect_none("R3 compare cycle");
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      expect_commit("R4 R5 R8 in-order commit", 5'(k + 1), (k % 3) == 0, val_of(k), addr_of(k));
    end
    @(negedge clk);
    expect_none("R5 drained");
    chk(!m_full && m_alloc_idx == 0, "R2 wrap", {m_full, m_alloc_idx}, 0);

    // R9: completion to the slot being allocated is ignored
    idle();
    alloc_pair(5'd7, 5'd7, 1'b0, 1'b0);
    done_m(0, val_of(40), addr_of(40));
    done_s(0, val_of(40), addr_of(40));
    repeat (4) begin
      @(negedge clk);
      idle();
      expect_none("R9 stale completion");
    end
    done_m(0, val_of(41), addr_of(41));
    done_s(0, val_of(41), addr_of(41));
    @(negedge clk);
    idle();
    expect_none("R9 compare cycle");
    @(negedge clk);
    expect_commit("R9 real completion", 5'd7, 1'b0, val_of(41), addr_of(41));

    // R6 R7: mismatch in each field (f=0..3), then a clean case (f=4)
    for (int f = 0; f < 5; f++) begin
      @(negedge clk);
      idle();
      base = int'(m_alloc_idx);
      for (int j = 0; j < 3; j++) begin
        if (j > 0) @(negedge clk);
        idle();
        alloc_pair(5'(j + 4), (f == 0 && j == 1) ? 5'((j + 4) ^ 1) : 5'(j + 4),
                   j == 2, (f == 1 && j == 1) ? 1'b1 : (j == 2));
      end
      for (int j = 2; j >= 0; j--) begin
        @(negedge clk);
        idle();
        done_m((base + j) % DEPTH, val_of(j + 20), addr_of(j + 20));
        done_s((base + j) % DEPTH, val_of(j + 20) ^ ((f == 2 && j == 1) ? 32'h1 : 32'h0),
               addr_of(j + 20) ^ ((f == 3 && j == 1) ? 32'h10 : 32'h0));
      end
      @(negedge clk);
      idle();
      expect_none("R6 compare cycle");
      @(negedge clk);
      expect_commit("R7 older entry commits", 5'd4, 1'b0, val_of(20), addr_of(20));
      if (f < 4) begin
        @(negedge clk);
        chk(flush == 1'b1, "R6 flush", flush, 1);
        chk(!rf_we && !mem_we, "R6 no write", {rf_we, mem_we}, 0);
        @(negedge clk);
        expect_none("R6 single pulse");
        chk(m_alloc_idx == 0 && s_alloc_idx == 0 && !m_full, "R7 emptied",
            {m_alloc_idx, s_alloc_idx, m_full}, 0);
        repeat (2) begin
          @(negedge clk);
          expect_none("R7 younger dropped");
        end
      end else begin
        @(negedge clk);
        expect_commit("R8 back-to-back", 5'd5, 1'b0, val_of(21), addr_of(21));
        @(negedge clk);
        expect_commit("R5 store", 5'd6, 1'b1, val_of(22), addr_of(22));
        @(negedge clk);
        expect_none("R5 idle");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule